// File: doc/BRIEF.md
# Stretched Processor Reset Generator

This block generates the processor reset from two asynchronous requests. The first is a supply-low flag from an external voltage comparator, active high. The second is a manual reset request, active low, which can come from a push button or from another logic output. Reset is asserted while either request is active. After both requests have gone away, reset stays asserted for a further hold period. This gives the supply and the processor time to settle.

The hold period is a parameter counted in clock cycles. The default corresponds to about 200 ms at 50 MHz, and simulation can use a much shorter value. Any request that arrives while the hold count is running restarts the count from zero. The hold window therefore also acts as the debounce filter for a bouncing switch. Reset is driven in both polarities. Both inputs pass through a two-flop synchronizer before use. The block's own asynchronous initialization input forces reset on, and a full hold period follows its release.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, `rst_n_o` is 0. A rising edge of `supply_low_i` placed between clock edges drives `rst_n_o` low at the third rising clock edge that follows.
- R2: When `supply_low_i` falls to 0 between clock edges and no request is active, `rst_n_o` stays 0 through rising edge HOLD_CYCLES+1 after the change. It rises to 1 at rising edge HOLD_CYCLES+2.
- R3: A 0 on `man_rst_n_i` asserts reset with the same latency and the same release timing as a 1 on `supply_low_i`.
- R4: Manual-reset bounces whose high gaps are shorter than the hold period never release reset. Release comes HOLD_CYCLES+2 edges after the last 0-to-1 transition of `man_rst_n_i`.
- R5: `rst_o` is the exact complement of `rst_n_o` in every cycle.
- R6: A request of one clock cycle or longer, arriving while the hold count is running, restarts the count from zero. Release then comes HOLD_CYCLES+2 edges after that request ends.
- R7: The hold counter never exceeds HOLD_CYCLES.
- R8: While `init_n` is 0, `rst_n_o` is 0 and `rst_o` is 1. After `init_n` rises with both requests inactive, `rst_n_o` rises at the HOLD_CYCLES+2 rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init_n | input | 1 | Asynchronous block initialization, active low |
| supply_low_i | input | 1 | Supply-low flag from external comparator, asynchronous, active high |
| man_rst_n_i | input | 1 | Manual reset request, asynchronous, active low |
| rst_n_o | output | 1 | Stretched reset, active low |
| rst_o | output | 1 | Stretched reset, active high |

## Verification
The assertions assume that `init_n` is low long enough to set the synchronizer and the counter, and that HOLD_CYCLES is at least 1. They also assume that any request the counter should see lasts at least one full clock period. A shorter pulse may fall between edges and never reach the synchronizer. The bench changes inputs only on falling clock edges and holds every request for at least one clock period. Its bounce gaps stay well below the hold period, so each edge count it expects is exact.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // Saturating increment of the hold counter.
  function automatic logic [31:0] sat_inc(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt >= lim) ? lim : cnt + 32'd1;
  endfunction

  // Counter width needed to hold values 0..lim.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             init_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge init_n) begin
      if (!init_n) begin
        stage1_q <= INIT_VAL[b];
        stage2_q <= INIT_VAL[b];
      end else begin
        stage1_q <= async_i[b];
        stage2_q <= stage1_q;
      end
    end
    assign sync_o[b] = stage2_q;
  end
endmodule

// File: rtl/srg_hold_timer.sv
module srg_hold_timer #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic init_n,
  input  logic cause_i,
  output logic released_o
);
  localparam int             CW     = srg_pkg::cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0]  HOLD_V = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_next;
  logic          released_q, release_d;

  always_comb begin
    cnt_next  = cause_i ? '0 : CW'(srg_pkg::sat_inc(32'(cnt_q), 32'(HOLD_CYCLES)));
    release_d = !cause_i && (cnt_next == HOLD_V);
  end

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      cnt_q      <= '0;
      released_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_next;
      released_q <= release_d;
    end
  end

  assign released_o = released_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!init_n)
    cnt_q <= HOLD_V);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!init_n)
    cause_i |=> (cnt_q == '0));

  assert_release_at_limit_R2: assert property (@(posedge clk) disable iff (!init_n)
    $rose(released_q) |-> (cnt_q == HOLD_V));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic init_n,
  input  logic supply_low_i,
  input  logic man_rst_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  // bit 1: supply-low (asserting value 1), bit 0: manual request (asserting value 0)
  logic [1:0] req_sync;
  logic       supply_low_s, man_rst_n_s;
  logic       cause;
  logic       released;

  srg_sync #(.WIDTH(2), .INIT_VAL(2'b10)) u_sync (
    .clk    (clk),
    .init_n (init_n),
    .async_i({supply_low_i, man_rst_n_i}),
    .sync_o (req_sync)
  );

  assign supply_low_s = req_sync[1];
  assign man_rst_n_s  = req_sync[0];
  assign cause        = supply_low_s | ~man_rst_n_s;

  srg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk       (clk),
    .init_n    (init_n),
    .cause_i   (cause),
    .released_o(released)
  );

  assign rst_n_o = released;
  assign rst_o   = ~released;

  assert_supply_asserts_R1: assert property (@(posedge clk) disable iff (!init_n)
    supply_low_s |=> !rst_n_o);

  assert_manual_asserts_R3: assert property (@(posedge clk) disable iff (!init_n)
    !man_rst_n_s |=> !rst_n_o);

  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!init_n)
    $rose(rst_n_o) |-> !$past(cause));
endmodule

// File: tb/sim_supply_reset_gen.sv
module sim_supply_reset_gen;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic init_n = 1'b0;
  logic supply_low = 1'b0;
  logic man_rst_n = 1'b1;
  logic rst_n, rst;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  supply_reset_gen #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .init_n(init_n), .supply_low_i(supply_low),
    .man_rst_n_i(man_rst_n), .rst_n_o(rst_n), .rst_o(rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
    checks++;
    if (rst !== ~rst_n) begin
      errors++;
      $display("FAIL R5: rst_o actual %b expected %b at %0t", rst, ~rst_n, $time);
    end
  endtask

  // Advance n rising edges, then sample 1 ns later.
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Caller has just changed an input at a falling edge; check release timing.
  task automatic expect_release(input string req);
    edges(HOLD + 1);
    check(req, rst_n, 1'b0);
    edges(1);
    check(req, rst_n, 1'b1);
  endtask

  task automatic t_init();
    @(negedge clk);
    check("R8", rst_n, 1'b0);
    check("R8", rst, 1'b1);
    init_n = 1'b1;
    expect_release("R8");
  endtask

  task automatic t_supply();
    @(negedge clk); supply_low = 1'b1;
    edges(2); check("R1", rst_n, 1'b1);
    edges(1); check("R1", rst_n, 1'b0);
    for (int i = 0; i < 30; i++) begin
      edges(1); check("R1", rst_n, 1'b0);
    end
    @(negedge clk); supply_low = 1'b0;
    expect_release("R2");
  endtask

  task automatic t_manual();
    @(negedge clk); man_rst_n = 1'b0;
    edges(2); check("R3", rst_n, 1'b1);
    edges(1); check("R3", rst_n, 1'b0);
    @(negedge clk); man_rst_n = 1'b1;
    expect_release("R3");
  endtask

  task automatic t_bounce();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); man_rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
        edges(1); if (k > 0 || i == 2) check("R4", rst_n, 1'b0);
      end
      @(negedge clk); man_rst_n = 1'b1;
      for (int i = 0; i < HOLD / 2; i++) begin
        edges(1); check("R4", rst_n, 1'b0);
      end
    end
    @(negedge clk); man_rst_n = 1'b0;
    edges(1);
    @(negedge clk); man_rst_n = 1'b1;
    expect_release("R4");
  endtask

  task automatic t_restart();
    @(negedge clk); supply_low = 1'b1;
    edges(4);
    @(negedge clk); supply_low = 1'b0;
    edges(12); check("R6", rst_n, 1'b0);
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    expect_release("R6");
    edges(40); check("R6", rst_n, 1'b1);
  endtask

  initial begin
    edges(3);
    t_init();
    t_supply();
    t_manual();
    t_bounce();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule